// File: doc/BRIEF.md
# PCI Error Status Register

This block keeps the error status word of a bus bridge's primary PCI interface. Error detectors in the bridge's master and target logic, and in two DMA master channels, report each error as a one-cycle pulse. Abort pulses carry a source code that says which master started the transaction. Each pulse latches a sticky flag in a 16-bit status word. Software reads that word and clears a flag by writing 1 to its bit position.

The block also drives a level interrupt to the local processor, but only for causes that qualify. Master-abort and target-abort flags are shared between the bridge's own master and the DMA channels. When a DMA channel sets one of them, the flag is visible to software but raises no interrupt. When the bridge's own master sets the same flag, it does. The detected-parity flag sets whether or not parity response is enabled. A separate data-parity flag records only master-side parity errors that the bridge reports while parity response is enabled. Two read-only bits always report slow device-select timing.

Top module: `pci_err_status`

## Requirements
- R1: After a synchronous reset every flag is clear and `irq` is low, so `rd_data` reads 16'h0400.
- R2: A write with 1 in a flag's bit position clears that flag at the next clock edge. A 0 in a bit position leaves that flag unchanged. Flags never set except from a hardware event.
- R3: When a hardware event and a write-1-to-clear hit the same flag in the same cycle, the flag ends set.
- R4: Bit 15 (detected parity) sets on a target write-data parity error, on a master read-data parity error from any source, or on an address parity error, whatever `par_resp_en` is.
- R5: Bit 14 sets when the bridge signals a system error on the bus.
- R6: Bit 13 sets on a master-abort and bit 12 on a target-abort received as master, whatever the source code. Source codes: 2'b00 bridge master, 2'b01 DMA channel 0, 2'b10 DMA channel 1, 2'b11 treated as a non-bridge source.
- R7: Bit 11 sets when the bridge, acting as target, ends a transaction with target-abort.
- R8: Bit 8 sets only on a master read-data parity error with source 2'b00 while `par_resp_en` is 1.
- R9: Bits 10:9 always read 2'b10. Bits 7:0 always read 0. Writes have no effect on any of these bits.
- R10: `irq` is high while bit 15, 14, 11 or 8 is set, or while bit 13 or bit 12 holds a cause latched from source 2'b00. Aborts latched only from DMA sources leave `irq` low.
- R11: `irq` stays high until software has cleared every qualifying cause. Clearing bit 13 or bit 12 also drops the bridge-sourced interrupt cause held for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_resp_en | input | 1 | Parity-error-response enable from the command register |
| ev_par_tgt_wr | input | 1 | Write-data parity error while target of an inbound write |
| ev_par_mst_rd | input | 1 | Read-data parity error while master of an outbound read |
| ev_par_mst_src | input | 2 | Source code for `ev_par_mst_rd` |
| ev_addr_par | input | 1 | Address parity error seen on the bus |
| ev_serr | input | 1 | Bridge signalled a system error |
| ev_mabort | input | 1 | Master-abort on a transaction started by a master |
| ev_mabort_src | input | 2 | Source code for `ev_mabort` |
| ev_tabort_mst | input | 1 | Target-abort received while master |
| ev_tabort_src | input | 2 | Source code for `ev_tabort_mst` |
| ev_tabort_tgt | input | 1 | Bridge as target ended a transaction with target-abort |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write data, 1 bits clear flags |
| rd_data | output | 16 | Current status word |
| irq | output | 1 | Level interrupt to the local processor |

## Verification
The hardest cases to reach from the ports are those where the rules meet in one abort flag. One is a write-1-to-clear that lands in the very cycle a new event sets the same flag. The other is a flag first latched by a DMA channel and later also by the bridge master, where the interrupt must follow the bridge cause and not the flag. The bench drives an event and the clearing write in the same cycle. It also stacks DMA and bridge aborts on bits 13 and 12 before clearing them in turn. It checks `irq` after each step, so an interrupt tied to the bare flag, or one that outlives the clear, shows up.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

    localparam int STAT_W = 16;

    typedef enum logic [1:0] {
        SRC_BRIDGE = 2'b00,
        SRC_DMA0   = 2'b01,
        SRC_DMA1   = 2'b10,
        SRC_OTHER  = 2'b11
    } err_src_e;

    localparam int B_DET_PAR  = 15;
    localparam int B_SYS_ERR  = 14;
    localparam int B_MST_ABT  = 13;
    localparam int B_RCV_TABT = 12;
    localparam int B_SIG_TABT = 11;
    localparam int B_MST_DPAR = 8;

    localparam logic [STAT_W-1:0] STICKY_MASK = 16'hF900;
    localparam logic [STAT_W-1:0] DIRECT_IRQ_MASK = 16'hC900;
    localparam logic [STAT_W-1:0] RO_TIMING_FIELD = 16'h0400;

    typedef struct packed {
        logic     par_tgt_wr;
        logic     par_mst_rd;
        err_src_e par_mst_src;
        logic     addr_par;
        logic     sys_err;
        logic     mabort;
        err_src_e mabort_src;
        logic     tabort_mst;
        err_src_e tabort_src;
        logic     tabort_tgt;
    } err_evt_t;

    function automatic logic is_bridge(err_src_e s);
        return s == SRC_BRIDGE;
    endfunction

endpackage

// File: rtl/err_evt_decode.sv
module err_evt_decode
    import pci_err_pkg::*;
(
    input  err_evt_t           evt,
    input  logic               par_resp_en,
    output logic [STAT_W-1:0]  set_vec,
    output logic               mab_irq_set,
    output logic               tab_irq_set
);

    always_comb begin
        set_vec = '0;
        set_vec[B_DET_PAR]  = evt.par_tgt_wr | evt.par_mst_rd | evt.addr_par;
        set_vec[B_SYS_ERR]  = evt.sys_err;
        set_vec[B_MST_ABT]  = evt.mabort;
        set_vec[B_RCV_TABT] = evt.tabort_mst;
        set_vec[B_SIG_TABT] = evt.tabort_tgt;
        set_vec[B_MST_DPAR] = evt.par_mst_rd & par_resp_en & is_bridge(evt.par_mst_src);
        mab_irq_set = evt.mabort & is_bridge(evt.mabort_src);
        tab_irq_set = evt.tabort_mst & is_bridge(evt.tabort_src);
    end

endmodule

// File: rtl/err_sticky_cell.sv
module err_sticky_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> q);

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);

    // R2
    no_self_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!set && !q) |=> !q);

endmodule

// File: rtl/pci_err_status.sv
module pci_err_status
    import pci_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              par_resp_en,
    input  logic              ev_par_tgt_wr,
    input  logic              ev_par_mst_rd,
    input  logic [1:0]        ev_par_mst_src,
    input  logic              ev_addr_par,
    input  logic              ev_serr,
    input  logic              ev_mabort,
    input  logic [1:0]        ev_mabort_src,
    input  logic              ev_tabort_mst,
    input  logic [1:0]        ev_tabort_src,
    input  logic              ev_tabort_tgt,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              irq
);

    err_evt_t          evt;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat_q;
    logic              mab_irq_set, tab_irq_set;
    logic              mab_pend, tab_pend;

    always_comb begin
        evt.par_tgt_wr  = ev_par_tgt_wr;
        evt.par_mst_rd  = ev_par_mst_rd;
        evt.par_mst_src = err_src_e'(ev_par_mst_src);
        evt.addr_par    = ev_addr_par;
        evt.sys_err     = ev_serr;
        evt.mabort      = ev_mabort;
        evt.mabort_src  = err_src_e'(ev_mabort_src);
        evt.tabort_mst  = ev_tabort_mst;
        evt.tabort_src  = err_src_e'(ev_tabort_src);
        evt.tabort_tgt  = ev_tabort_tgt;
    end

    err_evt_decode u_decode (
        .evt         (evt),
        .par_resp_en (par_resp_en),
        .set_vec     (set_vec),
        .mab_irq_set (mab_irq_set),
        .tab_irq_set (tab_irq_set)
    );

    assign clr_vec = wr_en ? wr_data : '0;

    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        if (STICKY_MASK[i]) begin : g_sticky
            err_sticky_cell u_cell (
                .clk (clk),
                .rst (rst),
                .set (set_vec[i]),
                .clr (clr_vec[i]),
                .q   (stat_q[i])
            );
        end else begin : g_fixed
            assign stat_q[i] = 1'b0;
        end
    end

    err_sticky_cell u_mab_pend (
        .clk (clk),
        .rst (rst),
        .set (mab_irq_set),
        .clr (clr_vec[B_MST_ABT]),
        .q   (mab_pend)
    );

    err_sticky_cell u_tab_pend (
        .clk (clk),
        .rst (rst),
        .set (tab_irq_set),
        .clr (clr_vec[B_RCV_TABT]),
        .q   (tab_pend)
    );

    assign rd_data = stat_q | RO_TIMING_FIELD;
    assign irq     = (|(stat_q & DIRECT_IRQ_MASK)) | mab_pend | tab_pend;

    // R10
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(rd_data & STICKY_MASK)));

    // R8
    mdpe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_resp_en && !rd_data[B_MST_DPAR]) |=> !rd_data[B_MST_DPAR]);

    // R11
    mab_pend_flag_chk: assert property (@(posedge clk) disable iff (rst)
        mab_pend |-> rd_data[B_MST_ABT]);

    // R11
    tab_pend_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tab_pend |-> rd_data[B_RCV_TABT]);

endmodule

// File: tb/tb_pci_err_status.sv
module tb_pci_err_status;

    logic        clk = 1'b0;
    logic        rst;
    logic        par_resp_en;
    logic        ev_par_tgt_wr, ev_par_mst_rd, ev_addr_par, ev_serr;
    logic        ev_mabort, ev_tabort_mst, ev_tabort_tgt;
    logic [1:0]  ev_par_mst_src, ev_mabort_src, ev_tabort_src;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pci_err_status dut (
        .clk(clk), .rst(rst), .par_resp_en(par_resp_en),
        .ev_par_tgt_wr(ev_par_tgt_wr), .ev_par_mst_rd(ev_par_mst_rd),
        .ev_par_mst_src(ev_par_mst_src), .ev_addr_par(ev_addr_par),
        .ev_serr(ev_serr), .ev_mabort(ev_mabort), .ev_mabort_src(ev_mabort_src),
        .ev_tabort_mst(ev_tabort_mst), .ev_tabort_src(ev_tabort_src),
        .ev_tabort_tgt(ev_tabort_tgt), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ev_par_tgt_wr = 0; ev_par_mst_rd = 0; ev_addr_par = 0; ev_serr = 0;
        ev_mabort = 0; ev_tabort_mst = 0; ev_tabort_tgt = 0;
        ev_par_mst_src = 2'b00; ev_mabort_src = 2'b00; ev_tabort_src = 2'b00;
        wr_en = 0; wr_data = 16'h0000;
    endtask

    task automatic check(string req, logic [15:0] exp_rd, logic exp_irq);
        n_tests++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     req, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    task automatic wr(logic [15:0] d);
        wr_en = 1; wr_data = d;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rst = 1; idle(); par_resp_en = 0;
        tick(); tick();
        rst = 0;
        tick();
        check("R1 reset state", 16'h0400, 1'b0);
    endtask

    task automatic t_parity();
        par_resp_en = 0;
        ev_par_tgt_wr = 1; tick(); idle();
        check("R4 target write parity, R10 irq", 16'h8400, 1'b1);
        wr(16'h8000);
        check("R2 clear bit 15", 16'h0400, 1'b0);
        ev_addr_par = 1; tick(); idle();
        check("R4 address parity", 16'h8400, 1'b1);
        wr(16'h8000);
        par_resp_en = 1;
        ev_par_mst_rd = 1; ev_par_mst_src = 2'b10; tick(); idle();
        check("R4 R8 DMA read parity leaves bit 8", 16'h8400, 1'b1);
        wr(16'h8000);
        par_resp_en = 0;
        ev_par_mst_rd = 1; ev_par_mst_src = 2'b00; tick(); idle();
        check("R8 bridge parity with response disabled", 16'h8400, 1'b1);
        wr(16'h8000);
        par_resp_en = 1;
        ev_par_mst_rd = 1; ev_par_mst_src = 2'b00; tick(); idle();
        check("R8 bridge parity with response enabled", 16'h8500, 1'b1);
        wr(16'h8000);
        check("R11 irq held by bit 8", 16'h0500, 1'b1);
        wr(16'h0100);
        check("R11 all causes cleared", 16'h0400, 1'b0);
        par_resp_en = 0;
    endtask

    task automatic t_write_zero();
        ev_serr = 1; tick(); idle();
        check("R5 system error flag", 16'h4400, 1'b1);
        wr(16'h0000);
        check("R2 write zero keeps flag", 16'h4400, 1'b1);
        wr(16'h3FFF);
        check("R2 R9 other ones keep bit 14", 16'h4400, 1'b1);
        wr(16'hFFFF);
        check("R9 read-only field survives all-ones write", 16'h0400, 1'b0);
    endtask

    task automatic t_dma_aborts();
        ev_mabort = 1; ev_mabort_src = 2'b01; tick(); idle();
        check("R6 R10 DMA0 master-abort no irq", 16'h2400, 1'b0);
        ev_tabort_mst = 1; ev_tabort_src = 2'b10; tick(); idle();
        check("R6 R10 DMA1 target-abort no irq", 16'h3400, 1'b0);
        ev_mabort = 1; ev_mabort_src = 2'b00; tick(); idle();
        check("R10 bridge master-abort raises irq", 16'h3400, 1'b1);
        wr(16'h2000);
        check("R11 clearing bit 13 drops bridge cause", 16'h1400, 1'b0);
        ev_tabort_mst = 1; ev_tabort_src = 2'b11; tick(); idle();
        check("R6 code 11 is non-bridge", 16'h1400, 1'b0);
        wr(16'h1000);
        ev_tabort_mst = 1; ev_tabort_src = 2'b00; tick(); idle();
        check("R6 R10 bridge target-abort raises irq", 16'h1400, 1'b1);
        wr(16'h1000);
        check("R11 clear bit 12", 16'h0400, 1'b0);
    endtask

    task automatic t_target_abort();
        ev_tabort_tgt = 1; tick(); idle();
        check("R7 signalled target-abort", 16'h0C00, 1'b1);
        wr(16'h0800);
        check("R7 cleared", 16'h0400, 1'b0);
    endtask

    task automatic t_collision();
        ev_serr = 1; wr_en = 1; wr_data = 16'h4000; tick(); idle();
        check("R3 set beats same-cycle clear", 16'h4400, 1'b1);
        ev_mabort = 1; ev_mabort_src = 2'b00; wr_en = 1; wr_data = 16'h2000;
        tick(); idle();
        check("R3 bridge abort beats clear, irq kept", 16'h6400, 1'b1);
        wr(16'h6000);
        check("R3 plain clear afterwards", 16'h0400, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_parity();
                t_write_zero();
                t_dma_aborts();
                t_target_abort();
                t_collision();
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule